// File: doc/BRIEF.md
# PCI Outbound Window Address Translator

This block sits between a processor's local bus and an outbound PCI requester. It turns local accesses that land in three fixed local windows into PCI requests. The windows are a 128 MB memory window, a 64 KB I/O window and a one-word configuration port. Two base registers choose where the memory and I/O windows look into their 4 GB PCI spaces. Changing a base register moves the remote view but never moves the local window. The low local address bits pass straight through, and the base register supplies the high bits.

Configuration space is reached through one data word in two phases. The first write to the port holds a target address. The next access then runs a configuration write, or a configuration read, at that address. The value from the last configuration read is kept, so plain reads of the port return it with no new bus cycle.

Every translated access is non-posted. The request output stays asserted with stable fields until the completion handshake returns. Local ready is given only in that completion cycle. Accesses that need no bus cycle complete at once. These are misses, the configuration address phase, and a configuration read with no address held.

Top module: `pci_outwin_xlate`

## Requirements
- R1: After reset the request output is low, both base registers read 0, the configuration port holds no address, and a read of the port completes at once with data 0.
- R2: A local access in 0xE000_0000..0xE7FF_FFFF issues a request with space code 2'b00 and address {memory base[31:27], local address[26:0]}.
- R3: A local access in 0xEEFE_0000..0xEEFE_FFFF issues a request with space code 2'b01 and address {I/O base[31:16], local address[15:0]}.
- R4: The base register selected by reg_sel (0 memory, 1 I/O) reads back what was written, with bits below 27 (memory) or below 16 (I/O) forced to 0.
- R5: A local access outside all three windows completes in the cycle it is presented, with loc_ready high and loc_rdata 0, and raises no request.
- R6: A request keeps out_req high and its space, direction, address and write data stable until out_done. loc_ready stays low until then and rises in the out_done cycle, carrying out_rdata on reads.
- R7: With no address held, a write to the configuration port at 0xEEFF_FFFC completes at once, raises no request, and holds the written word as the configuration address.
- R8: With an address held, a write to the port issues a request with space code 2'b10, direction write, the held address and the new data. After it completes, no address is held.
- R9: With an address held, a read of the port keeps loc_ready low and issues a space 2'b10 read at the held address. It completes with the returned data in the out_done cycle.
- R10: With no address held, reads of the port complete at once, raise no request, and return the data of the last completed configuration read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Base register write strobe |
| reg_sel | input | 1 | Base register select: 0 memory, 1 I/O |
| reg_wdata | input | 32 | Base register write data |
| reg_rdata | output | 32 | Selected base register value |
| loc_valid | input | 1 | Local access present, held until loc_ready |
| loc_write | input | 1 | Local access is a write |
| loc_addr | input | 32 | Local byte address |
| loc_wdata | input | 32 | Local write data |
| loc_ready | output | 1 | Local access completes this cycle |
| loc_rdata | output | 32 | Local read data, valid with loc_ready |
| out_req | output | 1 | Translated request pending |
| out_space | output | 2 | Space code: 00 memory, 01 I/O, 10 configuration |
| out_write | output | 1 | Translated request is a write |
| out_addr | output | 32 | PCI address |
| out_wdata | output | 32 | PCI write data |
| out_done | input | 1 | Completion of the pending request |
| out_rdata | input | 32 | Read data returned with out_done |

## Verification
The hardest case to reach is a configuration read that meets a held address. The local side must already be waiting with ready low, and the outcome only shows on the following plain reads of the port. The stimulus first writes an address to the port and then presents a read. A responder task holds out_done back for several cycles to check the wait. Repeated reads then confirm that the captured value comes back with no new request. A second write after a completed configuration write checks that the port went back to taking an address.

// File: rtl/pci_ow_pkg.sv
package pci_ow_pkg;
  localparam int unsigned AW = 32;

  typedef enum logic [1:0] {
    SP_MEM = 2'b00,
    SP_IO  = 2'b01,
    SP_CFG = 2'b10
  } space_e;

  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_ADDR = 2'd1,
    CP_BUSY = 2'd2
  } cfgst_e;

  // mask of the bits a window of 2**lowbits bytes passes through
  function automatic logic [AW-1:0] low_mask(input int unsigned lowbits);
    return (({{(AW-1){1'b0}}, 1'b1}) << lowbits) - 1'b1;
  endfunction

  // high bits from the base, low bits from the local address
  function automatic logic [AW-1:0] splice(input logic [AW-1:0] base,
                                           input logic [AW-1:0] addr,
                                           input int unsigned lowbits);
    return (base & ~low_mask(lowbits)) | (addr & low_mask(lowbits));
  endfunction
endpackage

// File: rtl/pci_ow_decode.sv
module pci_ow_decode
  import pci_ow_pkg::*;
#(
  parameter logic [31:0] MEM_LOCAL = 32'hE000_0000,
  parameter int unsigned MEM_BITS  = 27,
  parameter logic [31:0] IO_LOCAL  = 32'hEEFE_0000,
  parameter int unsigned IO_BITS   = 16,
  parameter logic [31:0] CFG_PORT  = 32'hEEFF_FFFC
) (
  input  logic [AW-1:0] addr,
  output logic          hit_mem,
  output logic          hit_io,
  output logic          hit_cfg,
  output logic          miss
);
  always_comb begin
    hit_mem = (addr >> MEM_BITS) == (MEM_LOCAL >> MEM_BITS);
    hit_io  = (addr >> IO_BITS) == (IO_LOCAL >> IO_BITS);
    hit_cfg = addr[AW-1:2] == CFG_PORT[AW-1:2];
    miss    = !(hit_mem || hit_io || hit_cfg);
  end
endmodule

// File: rtl/pci_ow_basereg.sv
module pci_ow_basereg
  import pci_ow_pkg::*;
#(
  parameter int unsigned MEM_BITS = 27,
  parameter int unsigned IO_BITS  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic [AW-1:0] mem_base,
  output logic [AW-1:0] io_base
);
  localparam logic [AW-1:0] MEM_KEEP = ~low_mask(MEM_BITS);
  localparam logic [AW-1:0] IO_KEEP  = ~low_mask(IO_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_base <= '0;
      io_base  <= '0;
    end else if (we) begin
      if (sel) io_base  <= wdata & IO_KEEP;
      else     mem_base <= wdata & MEM_KEEP;
    end
  end

  assign rdata = sel ? io_base : mem_base;
endmodule

// File: rtl/pci_ow_cfgport.sv
module pci_ow_cfgport
  import pci_ow_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  input  logic          done,
  input  logic [AW-1:0] rdata,
  output cfgst_e        state,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] data_q,
  output logic          launch
);
  logic rd_pend;

  assign launch = sel && (state == CP_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= CP_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      rd_pend <= 1'b0;
    end else begin
      unique case (state)
        CP_IDLE: if (sel && wr) begin
          addr_q <= wdata;
          state  <= CP_ADDR;
        end
        CP_ADDR: if (sel) begin
          rd_pend <= !wr;
          state   <= CP_BUSY;
        end
        CP_BUSY: if (done) begin
          if (rd_pend) data_q <= rdata;
          state <= CP_IDLE;
        end
        default: state <= CP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_outwin_xlate.sv
module pci_outwin_xlate
  import pci_ow_pkg::*;
#(
  parameter logic [31:0] MEM_LOCAL = 32'hE000_0000,
  parameter int unsigned MEM_BITS  = 27,
  parameter logic [31:0] IO_LOCAL  = 32'hEEFE_0000,
  parameter int unsigned IO_BITS   = 16,
  parameter logic [31:0] CFG_PORT  = 32'hEEFF_FFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        loc_valid,
  input  logic        loc_write,
  input  logic [31:0] loc_addr,
  input  logic [31:0] loc_wdata,
  output logic        loc_ready,
  output logic [31:0] loc_rdata,
  output logic        out_req,
  output logic [1:0]  out_space,
  output logic        out_write,
  output logic [31:0] out_addr,
  output logic [31:0] out_wdata,
  input  logic        out_done,
  input  logic [31:0] out_rdata
);
  logic          hit_mem, hit_io, hit_cfg, win_miss;
  logic [AW-1:0] mem_base, io_base;
  logic [AW-1:0] cfg_addr, cfg_data;
  cfgst_e        cfg_state;
  logic [1:0]    cfg_state_w;
  logic          cfg_sel, cfg_launch;
  logic          imm_done, done_now, issue;

  pci_ow_decode #(
    .MEM_LOCAL(MEM_LOCAL), .MEM_BITS(MEM_BITS),
    .IO_LOCAL(IO_LOCAL), .IO_BITS(IO_BITS), .CFG_PORT(CFG_PORT)
  ) u_dec (
    .addr(loc_addr), .hit_mem(hit_mem), .hit_io(hit_io),
    .hit_cfg(hit_cfg), .miss(win_miss)
  );

  pci_ow_basereg #(.MEM_BITS(MEM_BITS), .IO_BITS(IO_BITS)) u_base (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .mem_base(mem_base), .io_base(io_base)
  );

  assign done_now = out_req && out_done;
  assign cfg_sel  = loc_valid && hit_cfg && !out_req;

  pci_ow_cfgport u_cfg (
    .clk(clk), .rst_n(rst_n), .sel(cfg_sel), .wr(loc_write),
    .wdata(loc_wdata), .done(done_now), .rdata(out_rdata),
    .state(cfg_state), .addr_q(cfg_addr), .data_q(cfg_data),
    .launch(cfg_launch)
  );

  assign cfg_state_w = cfg_state;

  // accesses finished without a bus cycle
  assign imm_done = !out_req && loc_valid &&
                    (win_miss || (hit_cfg && cfg_state == CP_IDLE));
  // accesses that start a bus cycle
  assign issue    = !out_req && loc_valid && (hit_mem || hit_io || cfg_launch);

  assign loc_ready = imm_done || done_now;
  assign loc_rdata = done_now ? out_rdata :
                     (imm_done && hit_cfg) ? cfg_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_req   <= 1'b0;
      out_space <= SP_MEM;
      out_write <= 1'b0;
      out_addr  <= '0;
      out_wdata <= '0;
    end else if (issue) begin
      out_req   <= 1'b1;
      out_write <= loc_write;
      out_wdata <= loc_wdata;
      if (hit_mem) begin
        out_space <= SP_MEM;
        out_addr  <= splice(mem_base, loc_addr, MEM_BITS);
      end else if (hit_io) begin
        out_space <= SP_IO;
        out_addr  <= splice(io_base, loc_addr, IO_BITS);
      end else begin
        out_space <= SP_CFG;
        out_addr  <= cfg_addr;
      end
    end else if (done_now) begin
      out_req <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_outwin_xlate_chk.sv
module pci_outwin_xlate_chk #(
  parameter int unsigned MEM_BITS = 27,
  parameter logic [31:0] CFG_PORT = 32'hEEFF_FFFC
) (
  input logic        clk,
  input logic        rst_n,
  input logic        loc_valid,
  input logic        loc_write,
  input logic [31:0] loc_addr,
  input logic        loc_ready,
  input logic        out_req,
  input logic        out_done,
  input logic [1:0]  out_space,
  input logic        out_write,
  input logic [31:0] out_addr,
  input logic [31:0] out_wdata,
  input logic        win_miss,
  input logic        issue,
  input logic        hit_mem,
  input logic [31:0] mem_base,
  input logic [1:0]  cfg_state,
  input logic [31:0] cfg_addr
);
  localparam logic [31:0] LOW = (32'h1 << MEM_BITS) - 32'h1;

  logic at_port;
  assign at_port = loc_addr[31:2] == CFG_PORT[31:2];

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_done) |=> (out_req && $stable(out_addr) && $stable(out_space)
                                && $stable(out_write) && $stable(out_wdata)));

  // R5
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_req && loc_valid && win_miss) |=> !out_req);

  // R2
  mem_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && hit_mem) |=> (out_space == 2'b00 &&
      ((out_addr ^ $past(loc_addr)) & LOW) == 32'h0 &&
      ((out_addr ^ $past(mem_base)) & ~LOW) == 32'h0));

  // R7
  cfg_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_req && loc_valid && at_port && loc_write && cfg_state == 2'd0)
      |=> (cfg_state == 2'd1 && !out_req));

  // R8
  cfg_issue_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && at_port && cfg_state == 2'd1)
      |=> (out_space == 2'b10 && out_addr == $past(cfg_addr)));

  // R9
  cfg_rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_req && loc_valid && at_port && !loc_write && cfg_state == 2'd1) |-> !loc_ready);
endmodule

bind pci_outwin_xlate pci_outwin_xlate_chk #(.MEM_BITS(MEM_BITS), .CFG_PORT(CFG_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_write(loc_write),
  .loc_addr(loc_addr), .loc_ready(loc_ready), .out_req(out_req),
  .out_done(out_done), .out_space(out_space), .out_write(out_write),
  .out_addr(out_addr), .out_wdata(out_wdata), .win_miss(win_miss),
  .issue(issue), .hit_mem(hit_mem), .mem_base(mem_base),
  .cfg_state(cfg_state_w), .cfg_addr(cfg_addr)
);

// File: tb/pci_outwin_xlate_tb.sv
`timescale 1ns/1ps
module pci_outwin_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        loc_valid = 1'b0, loc_write = 1'b0;
  logic [31:0] loc_addr = '0, loc_wdata = '0;
  logic        loc_ready;
  logic [31:0] loc_rdata;
  logic        out_req, out_write;
  logic [1:0]  out_space;
  logic [31:0] out_addr, out_wdata;
  logic        out_done = 1'b0;
  logic [31:0] out_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  localparam logic [31:0] PORT = 32'hEEFF_FFFC;

  always #2 clk = ~clk;

  pci_outwin_xlate u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic set_base(input logic sel, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  // access answered by a bus cycle after lat wait cycles
  task automatic bus_access(input string req, input logic wr, input logic [31:0] a,
                            input logic [31:0] wd, input logic [1:0] sp,
                            input logic [31:0] pa, input int lat, input logic [31:0] rd);
    @(negedge clk); loc_valid = 1'b1; loc_write = wr; loc_addr = a; loc_wdata = wd;
    #1 chk({req, " ready low at start"}, loc_ready, 1'b0);
    @(negedge clk);
    chk({req, " req"}, out_req, 1'b1);
    chk({req, " space"}, out_space, sp);
    chk({req, " addr"}, out_addr, pa);
    chk({req, " dir"}, out_write, wr);
    if (wr) chk({req, " wdata"}, out_wdata, wd);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R6 held req", out_req, 1'b1);
      chk("R6 held addr", out_addr, pa);
      chk("R6 ready waits", loc_ready, 1'b0);
    end
    out_done = 1'b1; out_rdata = rd;
    #1 chk("R6 ready on done", loc_ready, 1'b1);
    if (!wr) chk({req, " rdata"}, loc_rdata, rd);
    @(negedge clk); out_done = 1'b0; loc_valid = 1'b0;
    #1 chk("R6 req cleared", out_req, 1'b0);
  endtask

  // access that finishes without a bus cycle
  task automatic quick_access(input string req, input logic wr, input logic [31:0] a,
                              input logic [31:0] wd, input logic [31:0] rd);
    @(negedge clk); loc_valid = 1'b1; loc_write = wr; loc_addr = a; loc_wdata = wd;
    #1 chk({req, " ready"}, loc_ready, 1'b1);
    if (!wr) chk({req, " rdata"}, loc_rdata, rd);
    @(negedge clk); loc_valid = 1'b0;
    chk({req, " no req"}, out_req, 1'b0);
    @(negedge clk);
    chk({req, " no req later"}, out_req, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 req", out_req, 1'b0);
    reg_sel = 1'b0; #1 chk("R1 mem base", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1 chk("R1 io base", reg_rdata, 32'h0);
    quick_access("R1 cfg read", 1'b0, PORT, 32'h0, 32'h0);
  endtask

  task automatic t_bases;
    set_base(1'b0, 32'hFFFF_FFFF);
    reg_sel = 1'b0; #1 chk("R4 mem base", reg_rdata, 32'hF800_0000);
    set_base(1'b1, 32'h1234_5678);
    reg_sel = 1'b1; #1 chk("R4 io base", reg_rdata, 32'h1234_0000);
    reg_sel = 1'b0; #1 chk("R4 mem base kept", reg_rdata, 32'hF800_0000);
  endtask

  task automatic t_mem;
    bus_access("R2 top", 1'b1, 32'hE7FF_FFFC, 32'hA5A5_0001, 2'b00,
               (32'hF800_0000 & 32'hF800_0000) | (32'hE7FF_FFFC & 32'h07FF_FFFF), 2, 32'h0);
    set_base(1'b0, 32'h1234_5678);
    bus_access("R2 read", 1'b0, 32'hE000_0010, 32'h0, 2'b00, 32'h1000_0010, 0, 32'hDEAD_BEEF);
    bus_access("R2 mid", 1'b1, 32'hE345_6788, 32'h0BAD_F00D, 2'b00, 32'h1345_6788, 1, 32'h0);
  endtask

  task automatic t_io;
    bus_access("R3 read", 1'b0, 32'hEEFE_ABCC, 32'h0, 2'b01, 32'h1234_ABCC, 3, 32'h5555_AAAA);
    set_base(1'b1, 32'hFFFF_0000);
    bus_access("R3 write", 1'b1, 32'hEEFE_0000, 32'h7777_1111, 2'b01, 32'hFFFF_0000, 0, 32'h0);
  endtask

  task automatic t_miss;
    quick_access("R5 below mem", 1'b0, 32'hDFFF_FFFC, 32'h0, 32'h0);
    quick_access("R5 above mem", 1'b1, 32'hE800_0000, 32'h1, 32'h0);
    quick_access("R5 below io", 1'b0, 32'hEEFD_FFFC, 32'h0, 32'h0);
    quick_access("R5 above io", 1'b0, 32'hEEFF_0000, 32'h0, 32'h0);
    quick_access("R5 beside port", 1'b0, 32'hEEFF_FFF8, 32'h0, 32'h0);
  endtask

  task automatic t_cfg;
    quick_access("R7 addr phase", 1'b1, PORT, 32'h8000_1234, 32'h0);
    bus_access("R8 cfg write", 1'b1, PORT, 32'hC0DE_0001, 2'b10, 32'h8000_1234, 1, 32'h0);
    // address no longer held: next write is an address phase again
    quick_access("R8 back to addr phase", 1'b1, PORT, 32'h8000_5678, 32'h0);
    bus_access("R9 cfg read", 1'b0, PORT, 32'h0, 2'b10, 32'h8000_5678, 4, 32'hCAFE_F00D);
    quick_access("R10 kept read", 1'b0, PORT, 32'h0, 32'hCAFE_F00D);
    quick_access("R10 kept read again", 1'b0, PORT, 32'h0, 32'hCAFE_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bases();
    t_mem();
    t_io();
    t_miss();
    t_cfg();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule